// File: doc/BRIEF.md
# UV EPROM Byte Programming Sequencer

This block programs a stream of bytes into an erased 2K x 8 UV-erasable EPROM. It drives the address bus, the data bus and its output enable, the output-enable pin and the combined chip-enable/program pin, and it enables the main supply and the programming supply. An erased cell reads 1. A program pulse can only clear chosen bits to 0, and only ultraviolet light sets them back to 1.

A run begins with `start`. The sequencer brings up the main supply, then the programming supply, and then takes bytes through a valid/ready stream, starting at `start_addr`. For each byte it first reads the cell. If the target byte needs a bit to go from 0 to 1, the byte is rejected at once and no pulse is issued. Otherwise it sets up address, data and output enable. It applies the program pulse, holds, and then performs a verify read. A parameter selects the pulse scheme: either one long pulse, or a short pulse followed by an over-program pulse.

A mismatch on verify stops the run and latches the failing address. A separate blank-check run reads every location with only the main supply on and reports the first location that is not 0xFF. All durations are counted in clock cycles, derived from a clock-frequency parameter and times given in microseconds.

Top module: `eprom_prog_seq`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `vcc_en`, `vpp_en`, `rom_pgm`, `rom_drive` and `wr_ready` are 0 and `rom_oe_n` is 1.
- R2: `vpp_en` is never 1 unless `vcc_en` is 1. `vcc_en` is alone for exactly the lead time before `vpp_en` rises. `vcc_en` stays on for exactly the lead time after `vpp_en` falls.
- R3: Before every program pulse, address, data and a high `rom_oe_n` are set up for at least the setup time. During a pulse, `vpp_en`, `rom_oe_n` and `rom_drive` are 1, and address and data do not change.
- R4: With the long-pulse scheme, each accepted byte receives exactly one pulse of exactly the long-pulse length in cycles.
- R5: With the short-pulse scheme, each accepted byte receives a short pulse and then an over-program pulse, each exactly its configured length.
- R6: After every pulse, the data bus stays driven with `rom_pgm` low for at least the hold time.
- R7: Bytes are written to consecutive addresses from `start_addr`. A run whose last byte (`wr_last`=1) verifies ends with a one-cycle `done` and `err_kind`=0. The cells then read the target values.
- R8: If a target byte has a 1 where the pre-read cell holds a 0, the run ends with `err_kind`=1 and `err_addr` set to that byte's address. No pulse is issued for that byte, and the cell keeps its content.
- R9: If the verify read differs from the target, the run ends with `err_kind`=2 and `err_addr` set to that address. No further bytes are accepted.
- R10: `blank_start` reads addresses 0 to 2^ADDR_W-1 with `vpp_en` kept at 0. It ends with `err_kind`=3 and the first address that does not read 0xFF, or with `err_kind`=0 if every location is erased.
- R11: `start` and `blank_start` are ignored while `busy` is 1.
- R12: `rom_drive` is never 1 while `rom_oe_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a programming run |
| blank_start | input | 1 | Begin a blank-check run |
| start_addr | input | ADDR_W | First address of a programming run |
| wr_valid | input | 1 | A byte is offered |
| wr_data | input | DATA_W | Target byte |
| wr_last | input | 1 | The offered byte is the last of the run |
| wr_ready | output | 1 | Sequencer accepts a byte this cycle |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run strobe |
| err | output | 1 | The last run ended with an error |
| err_kind | output | 2 | 0 none, 1 bit cannot be set, 2 verify mismatch, 3 not blank |
| err_addr | output | ADDR_W | Address of the failing location |
| rom_addr | output | ADDR_W | Device address bus |
| rom_wdata | output | DATA_W | Data driven to the device |
| rom_rdata | input | DATA_W | Data read from the device |
| rom_drive | output | 1 | Enable of the data driver toward the device |
| rom_oe_n | output | 1 | Device output enable, active low |
| rom_pgm | output | 1 | Chip-enable/program pin: 0 selects the device for reads, 1 is a program pulse |
| vcc_en | output | 1 | Main supply enable |
| vpp_en | output | 1 | Programming supply enable |

## Verification
A wrong phase state shows at the pins in the same cycle it is entered, because every pin is registered from the next state. A wrong pulse count or a wrong pulse length appears at the falling edge of `rom_pgm`, where the high cycles are compared with the configured length. A corrupt address or target register appears as a wrong cell value in the device model, or as a wrong `err_addr` at the `done` strobe that closes the run. A skipped supply phase shows up as a lead interval different from the configured one at the next rise or fall of `vpp_en`.

// File: rtl/eps_pkg.sv
package eps_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_VCC_UP,
    ST_VPP_UP,
    ST_FETCH,
    ST_PRE_RD,
    ST_SETUP,
    ST_PULSE,
    ST_HOLD,
    ST_VERIFY,
    ST_VPP_DN,
    ST_VCC_DN,
    ST_BLANK
  } eps_state_t;

  typedef enum logic [1:0] {
    EK_NONE      = 2'd0,
    EK_ZERO_TO_1 = 2'd1,
    EK_VERIFY    = 2'd2,
    EK_NOT_BLANK = 2'd3
  } eps_err_t;

  typedef struct packed {
    logic vcc;
    logic vpp;
    logic pgm;
    logic oe_n;
    logic drive;
    logic ready;
  } eps_pins_t;

  function automatic int unsigned us_to_cyc(input int unsigned khz, input int unsigned us);
    longint unsigned c;
    c = (longint'(khz) * longint'(us)) / 1000;
    if (c < 1) c = 1;
    return int'(c);
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/eps_timer.sv
module eps_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] val,
  output logic          zero
);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/eps_cmp.sv
module eps_cmp #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] target,
  input  logic [DW-1:0] rdback,
  output logic          needs_set,
  output logic          mismatch,
  output logic          not_erased
);

  logic [DW-1:0] set_bits;

  for (genvar i = 0; i < DW; i++) begin : g_bit
    assign set_bits[i] = target[i] & ~rdback[i];
  end

  assign needs_set  = |set_bits;
  assign mismatch   = (rdback != target);
  assign not_erased = (rdback != {DW{1'b1}});

endmodule

// File: rtl/eps_pins.sv
module eps_pins
  import eps_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  eps_state_t nxt,
  output eps_pins_t  pins
);

  eps_pins_t d;

  always_comb begin
    d.vcc   = !(nxt inside {ST_IDLE, ST_VCC_DN});
    d.vpp   = nxt inside {ST_VPP_UP, ST_FETCH, ST_PRE_RD, ST_SETUP,
                          ST_PULSE, ST_HOLD, ST_VERIFY};
    d.pgm   = (nxt == ST_PULSE);
    d.oe_n  = !(nxt inside {ST_PRE_RD, ST_VERIFY, ST_BLANK});
    d.drive = nxt inside {ST_SETUP, ST_PULSE, ST_HOLD};
    d.ready = (nxt == ST_FETCH);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pins <= '{vcc: 1'b0, vpp: 1'b0, pgm: 1'b0, oe_n: 1'b1, drive: 1'b0, ready: 1'b0};
    end else begin
      pins <= d;
    end
  end

endmodule

// File: rtl/eprom_prog_seq.sv
module eprom_prog_seq
  import eps_pkg::*;
#(
  parameter int          ADDR_W         = 11,
  parameter int          DATA_W         = 8,
  parameter int unsigned CLK_KHZ        = 50000,
  parameter bit          SHORT_MODE     = 1'b0,
  parameter int unsigned LONG_PULSE_US  = 50000,
  parameter int unsigned SHORT_PULSE_US = 1000,
  parameter int unsigned OVER_PULSE_US  = 2000,
  parameter int unsigned SETUP_US       = 2,
  parameter int unsigned HOLD_US        = 2,
  parameter int unsigned LEAD_US        = 2,
  parameter int unsigned READ_US        = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              blank_start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_last,
  output logic              wr_ready,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [1:0]        err_kind,
  output logic [ADDR_W-1:0] err_addr,
  output logic [ADDR_W-1:0] rom_addr,
  output logic [DATA_W-1:0] rom_wdata,
  input  logic [DATA_W-1:0] rom_rdata,
  output logic              rom_drive,
  output logic              rom_oe_n,
  output logic              rom_pgm,
  output logic              vcc_en,
  output logic              vpp_en
);

  localparam int unsigned C_LONG  = us_to_cyc(CLK_KHZ, LONG_PULSE_US);
  localparam int unsigned C_SHORT = us_to_cyc(CLK_KHZ, SHORT_PULSE_US);
  localparam int unsigned C_OVER  = us_to_cyc(CLK_KHZ, OVER_PULSE_US);
  localparam int unsigned C_SETUP = us_to_cyc(CLK_KHZ, SETUP_US);
  localparam int unsigned C_HOLD  = us_to_cyc(CLK_KHZ, HOLD_US);
  localparam int unsigned C_LEAD  = us_to_cyc(CLK_KHZ, LEAD_US);
  localparam int unsigned C_READ  = us_to_cyc(CLK_KHZ, READ_US);
  localparam int unsigned C_FIRST = SHORT_MODE ? C_SHORT : C_LONG;
  localparam int unsigned C_MAX   = max2(max2(max2(C_LONG, C_SHORT), max2(C_OVER, C_SETUP)),
                                         max2(max2(C_HOLD, C_LEAD), C_READ));
  localparam int          TW      = $clog2(C_MAX) + 1;

  localparam logic [TW-1:0] L_SETUP = TW'(C_SETUP - 1);
  localparam logic [TW-1:0] L_HOLD  = TW'(C_HOLD - 1);
  localparam logic [TW-1:0] L_LEAD  = TW'(C_LEAD - 1);
  localparam logic [TW-1:0] L_READ  = TW'(C_READ - 1);

  eps_state_t          state, ns;
  eps_err_t            ek_q;
  eps_pins_t           pins;
  logic [ADDR_W-1:0]   addr_q, eaddr_q;
  logic [DATA_W-1:0]   tgt_q;
  logic                last_q, over_q, blank_q, done_q;
  logic                t_load, t_zero;
  logic [TW-1:0]       t_val;
  logic                needs_set, mismatch, not_erased;
  logic [TW-1:0]       first_len, over_len;
  logic                has_over;
  logic                take;

  // Pulse scheme chosen at elaboration
  if (SHORT_MODE) begin : g_short
    assign first_len = TW'(C_SHORT - 1);
    assign over_len  = TW'(C_OVER - 1);
    assign has_over  = 1'b1;
  end else begin : g_long
    assign first_len = TW'(C_LONG - 1);
    assign over_len  = TW'(C_LONG - 1);
    assign has_over  = 1'b0;
  end

  eps_timer #(.TW(TW)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .load (t_load),
    .val  (t_val),
    .zero (t_zero)
  );

  eps_cmp #(.DW(DATA_W)) u_cmp (
    .target     (tgt_q),
    .rdback     (rom_rdata),
    .needs_set  (needs_set),
    .mismatch   (mismatch),
    .not_erased (not_erased)
  );

  eps_pins u_pins (
    .clk  (clk),
    .rst  (rst),
    .nxt  (ns),
    .pins (pins)
  );

  assign take = (state == ST_FETCH) && wr_valid && pins.ready;

  always_comb begin
    ns     = state;
    t_load = 1'b0;
    t_val  = '0;
    unique case (state)
      ST_IDLE: begin
        if (start || blank_start) begin
          ns = ST_VCC_UP; t_load = 1'b1; t_val = L_LEAD;
        end
      end
      ST_VCC_UP: begin
        if (t_zero) begin
          t_load = 1'b1;
          if (blank_q) begin
            ns = ST_BLANK; t_val = L_READ;
          end else begin
            ns = ST_VPP_UP; t_val = L_LEAD;
          end
        end
      end
      ST_VPP_UP: begin
        if (t_zero) ns = ST_FETCH;
      end
      ST_FETCH: begin
        if (take) begin
          ns = ST_PRE_RD; t_load = 1'b1; t_val = L_READ;
        end
      end
      ST_PRE_RD: begin
        if (t_zero) begin
          t_load = 1'b1;
          if (needs_set) begin
            ns = ST_VPP_DN; t_val = L_LEAD;
          end else begin
            ns = ST_SETUP; t_val = L_SETUP;
          end
        end
      end
      ST_SETUP: begin
        if (t_zero) begin
          ns = ST_PULSE; t_load = 1'b1;
          t_val = over_q ? over_len : first_len;
        end
      end
      ST_PULSE: begin
        if (t_zero) begin
          ns = ST_HOLD; t_load = 1'b1; t_val = L_HOLD;
        end
      end
      ST_HOLD: begin
        if (t_zero) begin
          t_load = 1'b1;
          if (has_over && !over_q) begin
            ns = ST_SETUP; t_val = L_SETUP;
          end else begin
            ns = ST_VERIFY; t_val = L_READ;
          end
        end
      end
      ST_VERIFY: begin
        if (t_zero) begin
          if (mismatch || last_q) begin
            ns = ST_VPP_DN; t_load = 1'b1; t_val = L_LEAD;
          end else begin
            ns = ST_FETCH;
          end
        end
      end
      ST_VPP_DN: begin
        if (t_zero) begin
          ns = ST_VCC_DN; t_load = 1'b1; t_val = L_LEAD;
        end
      end
      ST_VCC_DN: begin
        if (t_zero) ns = ST_IDLE;
      end
      ST_BLANK: begin
        if (t_zero) begin
          t_load = 1'b1;
          if (not_erased || (addr_q == {ADDR_W{1'b1}})) begin
            ns = ST_VCC_DN; t_val = L_LEAD;
          end else begin
            t_val = L_READ;
          end
        end
      end
      default: ns = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      addr_q  <= '0;
      eaddr_q <= '0;
      tgt_q   <= '0;
      last_q  <= 1'b0;
      over_q  <= 1'b0;
      blank_q <= 1'b0;
      done_q  <= 1'b0;
      ek_q    <= EK_NONE;
    end else begin
      state  <= ns;
      done_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start || blank_start) begin
            ek_q    <= EK_NONE;
            eaddr_q <= '0;
            blank_q <= !start;
            addr_q  <= start ? start_addr : '0;
          end
        end
        ST_FETCH: begin
          if (take) begin
            tgt_q  <= wr_data;
            last_q <= wr_last;
            over_q <= 1'b0;
          end
        end
        ST_PRE_RD: begin
          if (t_zero && needs_set) begin
            ek_q    <= EK_ZERO_TO_1;
            eaddr_q <= addr_q;
          end
        end
        ST_HOLD: begin
          if (t_zero && has_over) over_q <= 1'b1;
        end
        ST_VERIFY: begin
          if (t_zero) begin
            if (mismatch) begin
              ek_q    <= EK_VERIFY;
              eaddr_q <= addr_q;
            end else if (!last_q) begin
              addr_q <= addr_q + 1'b1;
            end
          end
        end
        ST_BLANK: begin
          if (t_zero) begin
            if (not_erased) begin
              ek_q    <= EK_NOT_BLANK;
              eaddr_q <= addr_q;
            end else if (addr_q != {ADDR_W{1'b1}}) begin
              addr_q <= addr_q + 1'b1;
            end
          end
        end
        ST_VCC_DN: begin
          if (t_zero) done_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign busy      = (state != ST_IDLE);
  assign done      = done_q;
  assign err       = (ek_q != EK_NONE);
  assign err_kind  = ek_q;
  assign err_addr  = eaddr_q;
  assign rom_addr  = addr_q;
  assign rom_wdata = tgt_q;
  assign rom_drive = pins.drive;
  assign rom_oe_n  = pins.oe_n;
  assign rom_pgm   = pins.pgm;
  assign vcc_en    = pins.vcc;
  assign vpp_en    = pins.vpp;
  assign wr_ready  = pins.ready;

endmodule

// File: rtl/eprom_prog_seq_chk.sv
module eprom_prog_seq_chk #(
  parameter int          ADDR_W   = 11,
  parameter int          DATA_W   = 8,
  parameter int unsigned P1       = 1,
  parameter int unsigned P2       = 1,
  parameter bit          HAS_OVER = 1'b0,
  parameter int unsigned SETUP    = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              rom_pgm,
  input logic              rom_oe_n,
  input logic              rom_drive,
  input logic              vcc_en,
  input logic              vpp_en,
  input logic              err,
  input logic [ADDR_W-1:0] rom_addr,
  input logic [DATA_W-1:0] rom_wdata
);

  logic [31:0] hi_cnt, su_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt <= '0;
      su_cnt <= '0;
    end else begin
      hi_cnt <= rom_pgm ? hi_cnt + 1 : '0;
      su_cnt <= (rom_drive && rom_oe_n && !rom_pgm) ? su_cnt + 1 : '0;
    end
  end

  AST_VPP_NEEDS_VCC: assert property (@(posedge clk) disable iff (rst)
    vpp_en |-> vcc_en); // R2
  AST_VPP_RISE_AFTER_VCC: assert property (@(posedge clk) disable iff (rst)
    $rose(vpp_en) |-> $past(vcc_en)); // R2
  AST_PULSE_CONDITIONS: assert property (@(posedge clk) disable iff (rst)
    rom_pgm |-> (vpp_en && rom_oe_n && rom_drive)); // R3
  AST_PULSE_BUS_STABLE: assert property (@(posedge clk) disable iff (rst)
    (rom_pgm && $past(rom_pgm)) |-> ($stable(rom_addr) && $stable(rom_wdata))); // R3
  AST_SETUP_MIN: assert property (@(posedge clk) disable iff (rst)
    $rose(rom_pgm) |-> (su_cnt >= SETUP)); // R3
  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $fell(rom_pgm) |-> ((hi_cnt == P1) || (HAS_OVER && (hi_cnt == P2)))); // R4 R5
  AST_NO_PULSE_AFTER_ERR: assert property (@(posedge clk) disable iff (rst)
    err |-> !rom_pgm); // R8
  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (rst)
    !rom_oe_n |-> !rom_drive); // R12

endmodule

bind eprom_prog_seq eprom_prog_seq_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .P1       (C_FIRST),
  .P2       (C_OVER),
  .HAS_OVER (SHORT_MODE),
  .SETUP    (C_SETUP)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rom_pgm   (rom_pgm),
  .rom_oe_n  (rom_oe_n),
  .rom_drive (rom_drive),
  .vcc_en    (vcc_en),
  .vpp_en    (vpp_en),
  .err       (err),
  .rom_addr  (rom_addr),
  .rom_wdata (rom_wdata)
);

// File: tb/eprom_model.sv
module eprom_model #(
  parameter int AW    = 11,
  parameter int STUCK = -1
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  input  logic          drive,
  input  logic          oe_n,
  input  logic          pgm,
  input  logic          vpp,
  output logic [7:0]    rdata
);

  logic [7:0] mem [0:(1<<AW)-1];

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = 8'hFF;
  end

  // A pulse clears the bits that are 0 in the driven byte; one cell never takes a charge
  always @(negedge clk) begin
    if (pgm && vpp && oe_n && drive && (int'(addr) != STUCK))
      mem[addr] <= mem[addr] & wdata;
  end

  assign rdata = (!pgm && !oe_n) ? mem[addr] : 8'hFF;

endmodule

// File: tb/eprom_prog_seq_test.sv
module eprom_prog_seq_test;

  localparam int AW = 11;
  localparam int LONG_C = 9, SHORT_C = 3, OVER_C = 6, SETUP_C = 2, HOLD_C = 2, LEAD_C = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1;
  int checks = 0, errors = 0;

  // long-pulse instance
  logic start = 0, blank_start = 0, wr_valid = 0, wr_last = 0;
  logic [AW-1:0] start_addr = '0;
  logic [7:0] wr_data = '0;
  logic wr_ready, busy, done, err, rom_drive, rom_oe_n, rom_pgm, vcc_en, vpp_en;
  logic [1:0] err_kind;
  logic [AW-1:0] err_addr, rom_addr;
  logic [7:0] rom_wdata, rom_rdata;

  // short-pulse instance
  logic s_start = 0, s_blank = 0, s_valid = 0, s_last = 0;
  logic [AW-1:0] s_saddr = '0;
  logic [7:0] s_data = '0;
  logic s_ready, s_busy, s_done, s_err, s_drive, s_oe_n, s_pgm, s_vcc, s_vpp;
  logic [1:0] s_kind;
  logic [AW-1:0] s_eaddr, s_addr;
  logic [7:0] s_wdata, s_rdata;

  eprom_prog_seq #(.ADDR_W(AW), .DATA_W(8), .CLK_KHZ(1000), .SHORT_MODE(1'b0),
    .LONG_PULSE_US(LONG_C), .SHORT_PULSE_US(SHORT_C), .OVER_PULSE_US(OVER_C),
    .SETUP_US(SETUP_C), .HOLD_US(HOLD_C), .LEAD_US(LEAD_C), .READ_US(1)) uut (
    .clk(clk), .rst(rst), .start(start), .blank_start(blank_start), .start_addr(start_addr),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_last(wr_last), .wr_ready(wr_ready),
    .busy(busy), .done(done), .err(err), .err_kind(err_kind), .err_addr(err_addr),
    .rom_addr(rom_addr), .rom_wdata(rom_wdata), .rom_rdata(rom_rdata), .rom_drive(rom_drive),
    .rom_oe_n(rom_oe_n), .rom_pgm(rom_pgm), .vcc_en(vcc_en), .vpp_en(vpp_en));

  eprom_model #(.AW(AW), .STUCK(32'h30)) mdl (
    .clk(clk), .addr(rom_addr), .wdata(rom_wdata), .drive(rom_drive), .oe_n(rom_oe_n),
    .pgm(rom_pgm), .vpp(vpp_en), .rdata(rom_rdata));

  eprom_prog_seq #(.ADDR_W(AW), .DATA_W(8), .CLK_KHZ(1000), .SHORT_MODE(1'b1),
    .LONG_PULSE_US(LONG_C), .SHORT_PULSE_US(SHORT_C), .OVER_PULSE_US(OVER_C),
    .SETUP_US(SETUP_C), .HOLD_US(HOLD_C), .LEAD_US(LEAD_C), .READ_US(1)) uut_s (
    .clk(clk), .rst(rst), .start(s_start), .blank_start(s_blank), .start_addr(s_saddr),
    .wr_valid(s_valid), .wr_data(s_data), .wr_last(s_last), .wr_ready(s_ready),
    .busy(s_busy), .done(s_done), .err(s_err), .err_kind(s_kind), .err_addr(s_eaddr),
    .rom_addr(s_addr), .rom_wdata(s_wdata), .rom_rdata(s_rdata), .rom_drive(s_drive),
    .rom_oe_n(s_oe_n), .rom_pgm(s_pgm), .vcc_en(s_vcc), .vpp_en(s_vpp));

  eprom_model #(.AW(AW), .STUCK(-1)) mdl_s (
    .clk(clk), .addr(s_addr), .wdata(s_wdata), .drive(s_drive), .oe_n(s_oe_n),
    .pgm(s_pgm), .vpp(s_vpp), .rdata(s_rdata));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // scoreboard of expected run results for the long-pulse instance
  typedef struct { logic [1:0] kind; logic [AW-1:0] addr; } exp_t;
  exp_t sb[$];

  task automatic expect_result(input logic [1:0] k, input logic [AW-1:0] a);
    exp_t e;
    e.kind = k; e.addr = a;
    sb.push_back(e);
  endtask

  always @(negedge clk) begin
    if (!rst && done) begin
      if (sb.size() == 0) begin
        check(1'b0, "R7 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(err_kind == e.kind, "R7/R8/R9/R10 kind", err_kind, e.kind);
        check(err_addr == e.addr, "R8/R9/R10 address", err_addr, e.addr);
      end
    end
  end

  // pin timing monitor for the long-pulse instance
  int hi = 0, su = 0, hd = 0, lc = 0, dn = 0, pulses = 0;
  bit holding = 0, armed = 0, in_blank = 0, blank_vpp = 0, fight = 0;
  logic pgm_p = 0, vpp_p = 0, vcc_p = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (rom_pgm) hi++;
      else if (hi != 0) begin
        check(hi == LONG_C, "R4 pulse width", hi, LONG_C);
        pulses++; hi = 0;
      end
      if (rom_pgm && !pgm_p) begin
        check(su >= SETUP_C, "R3 setup cycles", su, SETUP_C);
        su = 0;
      end else if (rom_drive && !rom_pgm) su++;
      else if (!rom_drive) su = 0;
      if (pgm_p && !rom_pgm) begin holding = 1; hd = 0; end
      if (holding) begin
        if (rom_drive && !rom_pgm) hd++;
        else begin
          check(hd >= HOLD_C, "R6 hold cycles", hd, HOLD_C);
          holding = 0;
        end
      end
      if (!vcc_en) lc = 0;
      else if (!vpp_en) lc++;
      if (vpp_en && !vpp_p) begin
        check(lc == LEAD_C, "R2 supply lead up", lc, LEAD_C);
        lc = 0;
      end
      if (!vpp_en && vpp_p) begin armed = 1; dn = 0; end
      if (armed && vcc_en && !vpp_en) dn++;
      if (!vcc_en && vcc_p && armed) begin
        check(dn == LEAD_C, "R2 supply lead down", dn, LEAD_C);
        armed = 0;
      end
      if (in_blank && vpp_en) blank_vpp = 1;
      if (!rom_oe_n && rom_drive) fight = 1;
      pgm_p = rom_pgm; vpp_p = vpp_en; vcc_p = vcc_en;
    end
  end

  // pulse monitor for the short-pulse instance
  int sw = 0, s_pulses = 0;
  bit s_phase = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (s_pgm) sw++;
      else if (sw != 0) begin
        check(sw == (s_phase ? OVER_C : SHORT_C), "R5 pulse width", sw, s_phase ? OVER_C : SHORT_C);
        s_phase = ~s_phase; s_pulses++; sw = 0;
      end
    end
  end

  task automatic pulse_start(input logic [AW-1:0] a);
    start_addr = a; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic send(input logic [7:0] d, input logic l);
    wr_valid = 1; wr_data = d; wr_last = l;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 0; wr_last = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    report();
  end

  initial begin
    int p0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check(!busy && !done && !err, "R1 status idle", {busy, done, err}, 0);
    check(!vcc_en && !vpp_en, "R1 supplies off", {vcc_en, vpp_en}, 0);
    check(!rom_pgm && rom_oe_n && !rom_drive && !wr_ready, "R1 pins",
          {rom_pgm, rom_oe_n, rom_drive, wr_ready}, 4'b0100);

    // R7 four bytes at 0x10, with R11 stray start mid-run
    mdl.mem[11'h20] = 8'h0F;
    p0 = pulses;
    expect_result(2'd0, '0);
    pulse_start(11'h010);
    send(8'hA5, 0);
    pulse_start(11'h100);
    send(8'h3C, 0);
    send(8'h00, 0);
    send(8'hFF, 1);
    wait_idle();
    check(mdl.mem[11'h10] == 8'hA5, "R7 cell 0x10", mdl.mem[11'h10], 8'hA5);
    check(mdl.mem[11'h11] == 8'h3C, "R7 cell 0x11", mdl.mem[11'h11], 8'h3C);
    check(mdl.mem[11'h12] == 8'h00, "R7 cell 0x12", mdl.mem[11'h12], 8'h00);
    check(mdl.mem[11'h13] == 8'hFF, "R7 cell 0x13", mdl.mem[11'h13], 8'hFF);
    check(pulses - p0 == 4, "R4 one pulse per byte", pulses - p0, 4);
    check(mdl.mem[11'h100] == 8'hFF, "R11 busy start ignored", mdl.mem[11'h100], 8'hFF);

    // R8 byte needing a 0 -> 1 change
    p0 = pulses;
    expect_result(2'd1, 11'h020);
    pulse_start(11'h01F);
    send(8'h55, 0);
    send(8'hF0, 0);
    wait_idle();
    check(pulses - p0 == 1, "R8 no pulse for rejected byte", pulses - p0, 1);
    check(mdl.mem[11'h20] == 8'h0F, "R8 cell unchanged", mdl.mem[11'h20], 8'h0F);
    check(mdl.mem[11'h1F] == 8'h55, "R7 cell 0x1F", mdl.mem[11'h1F], 8'h55);

    // R9 cell that does not program
    expect_result(2'd2, 11'h030);
    pulse_start(11'h030);
    send(8'h12, 0);
    wait_idle();
    begin
      bit taken = 0;
      wr_valid = 1; wr_data = 8'h77;
      repeat (20) begin
        @(negedge clk);
        if (wr_ready) taken = 1;
      end
      wr_valid = 0;
      check(!taken, "R9 no byte accepted after stop", taken, 0);
    end
    check(err, "R9 err flag", err, 1);

    // R10 blank check on a programmed device
    expect_result(2'd3, 11'h010);
    in_blank = 1;
    blank_start = 1;
    @(negedge clk);
    blank_start = 0;
    wait_idle();
    in_blank = 0;
    check(!blank_vpp, "R10 no program supply during blank check", blank_vpp, 0);

    // R10 clean device and R5 short scheme on the second instance
    s_blank = 1;
    @(negedge clk);
    s_blank = 0;
    @(negedge clk);
    while (s_busy) @(negedge clk);
    check(s_kind == 2'd0 && !s_err, "R10 erased device passes", s_kind, 0);

    s_saddr = 11'h7FF; s_start = 1;
    @(negedge clk);
    s_start = 0;
    s_valid = 1; s_data = 8'h81; s_last = 1;
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 0; s_last = 0;
    while (s_busy) @(negedge clk);
    check(s_kind == 2'd0, "R5 run result", s_kind, 0);
    check(s_pulses == 2, "R5 two pulses per byte", s_pulses, 2);
    check(mdl_s.mem[11'h7FF] == 8'h81, "R5 cell programmed", mdl_s.mem[11'h7FF], 8'h81);

    check(!fight, "R12 no bus fight", fight, 0);
    check(sb.size() == 0, "R7 all results seen", sb.size(), 0);
    repeat (4) @(negedge clk);
    report();
  end

endmodule